// File: doc/BRIEF.md
# Power-Management I/O Window with SCI Interrupt

This block decodes a relocatable 64-byte I/O window for the power-management function. It also holds the event status, event enable and control registers inside that window, together with a free-running timer. Configuration logic outside the block supplies two things: the base-address dword and a control byte whose bit 0 switches the window on. Only bits 15:6 of the base dword take part in the match, so the window always sits on a 64-byte boundary in the 16-bit I/O space.

Hardware event pulses set status bits. These are the real-time clock alarm, the power button and the global-lock release. A timer status bit is set when the timer's top bit flips. Software clears status bits by writing ones. The SCI output is a level. It stays high while any of four sources is both pending and enabled.

Top module: `pm_window_sci`

## Requirements
- R1: After reset the status, enable and control registers and the timer are all zero, and `sci` is low.
- R2: `io_hit` is high exactly when `cfg_ctl[0]` is 1 and `io_addr & 16'hFFC0` equals `cfg_base[15:0] & 16'hFFC0`. Bits 31:16 and 5:0 of `cfg_base` have no effect.
- R3: An access with `io_hit` low changes no register, and it returns `io_rdata` = 0.
- R4: Reads inside the window use `io_addr[5:1]` to select the register, and `io_addr[0]` is ignored. Offset 0x00 returns status and offset 0x02 returns enable. Offset 0x04 returns control and offset 0x08 returns timer bits 15:0. Offset 0x0A returns timer bits 31:16, zero-extended. Every other offset reads 0, and `io_rdata` is 0 when `io_rd` is low.
- R5: A pulse on `evt_rtc`, `evt_pwrbtn` or `evt_glbl` sets status bit 10, bit 8 or bit 5 respectively on the next clock edge.
- R6: Writing offset 0x00 clears each status bit whose data bit is 1. If an event sets a bit in the same cycle, the bit stays set.
- R7: `sci` equals the OR of (status AND enable) over bits 0, 5, 8 and 10. Clearing the last such pending bit drops `sci` one cycle after the write.
- R8: The timer (`TMR_W` bits) adds one on every cycle in which `tmr_tick` is high, wraps to zero, and software cannot write it.
- R9: Timer status (bit 0) sets on a tick that changes the timer's top bit, but only while enable bit 0 is 1 and status bit 0 is 0.
- R10: Writes to offsets 0x02 and 0x04 store all 16 data bits into enable and control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_base | input | 32 | Base-address dword from configuration space |
| cfg_ctl | input | 8 | Control byte from configuration space; bit 0 enables the window |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 16 | Read data, combinational |
| io_hit | output | 1 | Address falls inside the enabled window |
| tmr_tick | input | 1 | Timer advance enable |
| evt_rtc | input | 1 | Real-time clock alarm event pulse |
| evt_pwrbtn | input | 1 | Power button event pulse |
| evt_glbl | input | 1 | Global lock release event pulse |
| sci | output | 1 | Level interrupt to the system |

## Verification
Some properties are checked on every cycle:
- event pulses landing in status;
- write-one-to-clear on status;
- timer advance and hold;
- the zero read-back outside the window;
- `sci` staying low while nothing is enabled.

Other behaviour shows up only in the bench's scenarios:
- The exact window match against masked base values.
- The register map and the full-width enable and control storage.
- The tie between an event and a clear in the same cycle.
- The timer status arming rule, which needs hundreds of ticks around a top-bit flip.
- `sci` falling one cycle after the last pending bit is cleared.

// File: rtl/pm_window_sci.sv
module pm_window_sci #(
  parameter int TMR_W = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] cfg_base,
  input  logic [7:0]  cfg_ctl,
  input  logic [15:0] io_addr,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic [15:0] io_wdata,
  output logic [15:0] io_rdata,
  output logic        io_hit,
  input  logic        tmr_tick,
  input  logic        evt_rtc,
  input  logic        evt_pwrbtn,
  input  logic        evt_glbl,
  output logic        sci
);
  localparam logic [15:0] WIN_MASK = 16'hFFC0;
  localparam logic [15:0] SCI_SRC  = 16'h0521;

  logic [15:0]      sts, en_r, ctl_r;
  logic [TMR_W-1:0] tmr, tmr_nxt;
  logic [31:0]      tmr_ext;
  logic [15:0]      sts_set, sts_clr;
  logic [4:0]       sel;
  logic             wr_hit, tmr_flip, tmr_set;

  assign io_hit  = cfg_ctl[0] && ((io_addr & WIN_MASK) == (cfg_base[15:0] & WIN_MASK));
  assign sel     = io_addr[5:1];
  assign wr_hit  = io_hit && io_wr;
  assign tmr_nxt = tmr + 1'b1;
  assign tmr_ext = 32'(tmr);

  assign tmr_flip = tmr_tick && (tmr_nxt[TMR_W-1] != tmr[TMR_W-1]);
  assign tmr_set  = tmr_flip && en_r[0] && !sts[0];

  assign sts_set = {5'b0, evt_rtc, 1'b0, evt_pwrbtn, 2'b0, evt_glbl, 4'b0, tmr_set};
  assign sts_clr = (wr_hit && sel == 5'd0) ? (io_wdata & SCI_SRC) : 16'h0;

  assign sci = |(sts & en_r & SCI_SRC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts   <= '0;
      en_r  <= '0;
      ctl_r <= '0;
      tmr   <= '0;
    end else begin
      sts <= (sts & ~sts_clr) | sts_set;
      if (wr_hit && sel == 5'd1) en_r  <= io_wdata;
      if (wr_hit && sel == 5'd2) ctl_r <= io_wdata;
      if (tmr_tick) tmr <= tmr_nxt;
    end
  end

  always_comb begin
    io_rdata = 16'h0;
    if (io_hit && io_rd) begin
      case (sel)
        5'd0:    io_rdata = sts;
        5'd1:    io_rdata = en_r;
        5'd2:    io_rdata = ctl_r;
        5'd4:    io_rdata = tmr_ext[15:0];
        5'd5:    io_rdata = tmr_ext[31:16];
        default: io_rdata = 16'h0;
      endcase
    end
  end
endmodule

// File: rtl/pm_window_sci_chk.sv
module pm_window_sci_chk #(
  parameter int TMR_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic [15:0]      io_addr,
  input logic             io_wr,
  input logic [15:0]      io_wdata,
  input logic [15:0]      io_rdata,
  input logic             io_hit,
  input logic             tmr_tick,
  input logic             evt_rtc,
  input logic             evt_pwrbtn,
  input logic             evt_glbl,
  input logic             sci,
  input logic [15:0]      sts,
  input logic [15:0]      en_r,
  input logic [TMR_W-1:0] tmr
);
  a_r5_rtc_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rtc |=> sts[10]);
  a_r5_pwrbtn_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pwrbtn |=> sts[8]);
  a_r6_clear_rtc: assert property (@(posedge clk) disable iff (!rst_n)
    (io_hit && io_wr && io_addr[5:1] == 5'd0 && io_wdata[10] && !evt_rtc) |=> !sts[10]);
  a_r8_tick_adds: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_tick |=> tmr == TMR_W'($past(tmr) + 1'b1));
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_tick |=> $stable(tmr));
  a_r3_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !io_hit |-> io_rdata == 16'h0);
  a_r7_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    en_r == 16'h0 |-> !sci);
endmodule

bind pm_window_sci pm_window_sci_chk #(.TMR_W(TMR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
  .io_rdata(io_rdata), .io_hit(io_hit), .tmr_tick(tmr_tick), .evt_rtc(evt_rtc),
  .evt_pwrbtn(evt_pwrbtn), .evt_glbl(evt_glbl), .sci(sci), .sts(sts), .en_r(en_r),
  .tmr(tmr)
);

// File: tb/sim_pm_window_sci.sv
`timescale 1ns/1ps
module sim_pm_window_sci;
  localparam int TW = 10;

  logic clk = 0, rst_n = 0;
  logic [31:0] cfg_base = 0;
  logic [7:0]  cfg_ctl = 0;
  logic [15:0] io_addr = 0, io_wdata = 0;
  logic io_wr = 0, io_rd = 0, tmr_tick = 0, evt_rtc = 0, evt_pwrbtn = 0, evt_glbl = 0;
  logic [15:0] io_rdata;
  logic io_hit, sci;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [15:0] m_sts, m_en, m_ctl;
  logic [TW-1:0] m_tmr;

  always #4 clk = ~clk;

  pm_window_sci #(.TMR_W(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_ctl(cfg_ctl),
    .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .io_hit(io_hit), .tmr_tick(tmr_tick), .evt_rtc(evt_rtc),
    .evt_pwrbtn(evt_pwrbtn), .evt_glbl(evt_glbl), .sci(sci));

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic exp_hit(input logic [15:0] a);
    return cfg_ctl[0] && ((a & 16'hFFC0) == (cfg_base[15:0] & 16'hFFC0));
  endfunction

  function automatic logic [15:0] exp_read(input logic [15:0] a);
    logic [31:0] t = 32'(m_tmr);
    case (a[5:1])
      5'd0: return m_sts;
      5'd1: return m_en;
      5'd2: return m_ctl;
      5'd4: return t[15:0];
      5'd5: return t[31:16];
      default: return 16'h0;
    endcase
  endfunction

  task automatic step(input logic [15:0] a, input bit wr, input bit rd, input logic [15:0] d,
                      input bit tk, input bit rtc, input bit pb, input bit gl, input string tag);
    logic h, tflip, tset;
    logic [15:0] setv, clrv;
    logic [TW-1:0] nt;
    io_addr = a; io_wr = wr; io_rd = rd; io_wdata = d;
    tmr_tick = tk; evt_rtc = rtc; evt_pwrbtn = pb; evt_glbl = gl;
    #1;
    h = exp_hit(a);
    chk(io_hit === h, h ? "R2 hit" : "R2/R3 miss", 16'(io_hit), 16'(h));
    chk(io_rdata === ((h && rd) ? exp_read(a) : 16'h0), tag, io_rdata, (h && rd) ? exp_read(a) : 16'h0);
    chk(sci === (|(m_sts & m_en & 16'h0521)), "R7 sci", 16'(sci), 16'(|(m_sts & m_en & 16'h0521)));
    @(posedge clk);
    nt = m_tmr + 1'b1;
    tflip = tk && (nt[TW-1] != m_tmr[TW-1]);
    tset = tflip && m_en[0] && !m_sts[0];
    setv = 16'h0;
    setv[10] = rtc; setv[8] = pb; setv[5] = gl; setv[0] = tset;
    clrv = (h && wr && a[5:1] == 5'd0) ? (d & 16'h0521) : 16'h0;
    m_sts = (m_sts & ~clrv) | setv;
    if (h && wr && a[5:1] == 5'd1) m_en = d;
    if (h && wr && a[5:1] == 5'd2) m_ctl = d;
    if (tk) m_tmr = nt;
    @(negedge clk);
  endtask

  task automatic rd_reg(input logic [5:0] off, input string tag);
    step((cfg_base[15:0] & 16'hFFC0) | 16'(off), 0, 1, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic wr_reg(input logic [5:0] off, input logic [15:0] d, input string tag);
    step((cfg_base[15:0] & 16'hFFC0) | 16'(off), 1, 0, d, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = 32'h5A17;
    void'($urandom(seed));
    m_sts = 0; m_en = 0; m_ctl = 0; m_tmr = 0;
    cfg_base = 32'hABCD_1234;
    cfg_ctl = 8'h01;
    repeat (3) @(negedge clk);
    chk(sci === 1'b0, "R1 sci reset", 16'(sci), 16'h0);
    rst_n = 1;
    @(negedge clk);
    // R1: every register reads zero after reset
    rd_reg(6'h00, "R1 sts"); rd_reg(6'h02, "R1 en"); rd_reg(6'h04, "R1 ctl");
    rd_reg(6'h08, "R1 tmr lo"); rd_reg(6'h0A, "R1 tmr hi");
    // R2: low and high bits of base ignored; odd address maps like even (R4)
    rd_reg(6'h01, "R4 odd byte");
    chk(exp_hit(16'h1200) === 1'b1, "R2 masked base", 16'(exp_hit(16'h1200)), 16'h1);
    // R10: full-width storage
    wr_reg(6'h02, 16'hFFFF, "R10 en wr"); rd_reg(6'h02, "R10 en");
    wr_reg(6'h04, 16'hA5C3, "R10 ctl wr"); rd_reg(6'h04, "R10 ctl");
    rd_reg(6'h06, "R4 unmapped"); rd_reg(6'h3E, "R4 unmapped top");
    // R3: write outside the window leaves enable unchanged
    step(16'h1240, 1, 1, 16'h0000, 0, 0, 0, 0, "R3 miss wr");
    rd_reg(6'h02, "R3 en kept");
    cfg_ctl = 8'hFE;
    step(16'h1202, 1, 1, 16'h0000, 0, 0, 0, 0, "R2 disabled");
    cfg_ctl = 8'h01;
    rd_reg(6'h02, "R3 en kept disabled");
    // R5 events, R7 sci
    step(16'h0, 0, 0, 0, 0, 1, 0, 0, "R5 rtc");
    rd_reg(6'h00, "R5 rtc sts");
    step(16'h0, 0, 0, 0, 0, 0, 1, 1, "R5 pb gl");
    rd_reg(6'h00, "R5 pb gl sts");
    // R6: set wins over clear in same cycle
    step((cfg_base[15:0] & 16'hFFC0), 1, 0, 16'h0400, 0, 1, 0, 0, "R6 tie");
    rd_reg(6'h00, "R6 tie sts");
    chk(m_sts[10] === 1'b1, "R6 model tie", m_sts, 16'h0520);
    // R7: clear all, sci drops
    wr_reg(6'h00, 16'hFFFF, "R7 clear");
    chk(sci === 1'b0, "R7 sci drop", 16'(sci), 16'h0);
    // R9: timer status not set while disabled
    wr_reg(6'h02, 16'h0000, "R9 en off");
    for (int i = 0; i < (1 << (TW - 1)) + 4; i++) step(16'h0, 0, 0, 0, 1, 0, 0, 0, "R8 tick");
    rd_reg(6'h00, "R9 no sts when disabled");
    rd_reg(6'h08, "R8 timer value");
    wr_reg(6'h02, 16'h0001, "R9 en on");
    for (int i = 0; i < (1 << (TW - 1)); i++) step(16'h0, 0, 0, 0, 1, 0, 0, 0, "R8 tick");
    rd_reg(6'h00, "R9 sts set");
    chk(m_sts[0] === 1'b1 && sci === 1'b1, "R9 sci from timer", 16'(sci), 16'h1);
    rd_reg(6'h0A, "R4 tmr hi");
    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      if ($urandom % 8 == 0) cfg_ctl = 8'($urandom);
      if ($urandom % 64 == 0) cfg_base = $urandom;
      a = ($urandom % 2) ? ((cfg_base[15:0] & 16'hFFC0) | 16'($urandom % 12)) : 16'($urandom);
      step(a, ($urandom % 4) == 0, ($urandom % 2) == 0, 16'($urandom),
           ($urandom % 4) != 0, ($urandom % 50) == 0, ($urandom % 50) == 0,
           ($urandom % 50) == 0, "R4 random read");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule